// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a high-precision event timer. It watches a free-running main counter that is shared across channels, and it emits a one-clock expiry pulse when that counter reaches the channel's comparator. Interrupt routing, status latching and the bus decoder are separate neighbouring blocks. They pass in the write strobes and configuration bits and receive the pulse and the comparator value.

A channel runs in one-shot mode or in periodic mode. In periodic mode a hidden period register reloads the comparator after each expiry. A set-value strobe lets the next comparator write reach the comparator itself, not only the period. A 32-bit mode narrows the channel to the low word of the counter. In that mode, a one-shot channel also signals when the low word of the counter rolls over.

Top module: `evt_cmp_channel`

## Requirements
- R1: In periodic mode with a non-zero period, an expiry adds the period to the comparator. The addition repeats on later cycles, one per clock, until the comparator lies ahead of the counter. The channel gives one pulse for the expiry and no pulse during the extra additions.
- R2: A write to the low or high comparator word updates that half of the comparator when the channel is one-shot, or when the set-value flag is 1. In periodic mode the write always updates the same half of the period. The set-value flag is raised by `setval_arm` and is cleared by any comparator write.
- R3: When written, the period's top bit is forced to 0. This is bit 31 in 32-bit mode and bit 63 otherwise.
- R4: While `narrow` is 1, bits 63:32 of the comparator and the period read as 0 from the next cycle. Expiry is then decided on the low 32 bits of the counter only.
- R5: In 32-bit one-shot mode, an armed channel pulses once when the low word of the counter rolls over from 0xFFFFFFFF to a smaller value. It also pulses once at the comparator match. A rollover in the same cycle as the match gives a single pulse. In 64-bit mode a carry out of bit 31 gives no pulse.
- R6: The counter has reached the comparator when (comparator − counter), taken as a signed value at the active width, is zero or negative. Equality counts as expired, and wraparound is handled by the sign of the difference.
- R7: A 0→1 change of `ch_en` arms the channel and a 1→0 change disarms it. No pulse is produced while `glb_en` or `ch_en` is 0.
- R8: A comparator write re-arms the channel when `glb_en` and `ch_en` are both 1. A write while `glb_en` is 0 does not arm it.
- R9: `expire` is high for exactly the one cycle after the clock edge at which an armed, enabled channel sees the counter reach the comparator. A one-shot channel then disarms.
- R10: After reset the comparator is all ones, the period is 0, the set-value flag is 0 and `expire` is 0. A periodic channel whose period is 0 behaves as one-shot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| main_cnt | input | 64 | Shared main counter value |
| glb_en | input | 1 | Global enable; gates all expiry pulses |
| ch_en | input | 1 | Channel enable; rising edge arms, falling edge disarms |
| periodic | input | 1 | 1 = periodic auto-reload, 0 = one-shot |
| narrow | input | 1 | 1 = 32-bit mode |
| setval_arm | input | 1 | Raises the set-value flag for the next comparator write |
| wr_lo | input | 1 | Write strobe, low comparator word |
| wr_hi | input | 1 | Write strobe, high comparator word |
| wr_data | input | 32 | Write data for either word |
| expire | output | 1 | One-cycle expiry pulse |
| cmp_val | output | 64 | Current comparator value |

## Verification
In 32-bit one-shot mode the rollover event and the comparator match can land on the same clock. The bench provokes this by setting the comparator to 0 and stepping the counter from 0xFFFFFFFE through 0xFFFFFFFF to a low word of 0. Both conditions then become true on one edge. The bench judges it by counting pulses afterwards: exactly one pulse must appear and none after it, because the match disarms the channel. A second run with a comparator of 0x10 keeps the two apart and must give two pulses. A third run crosses the same boundary in 64-bit mode and must give only the match pulse.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 2 * WORD_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_WATCH  = 2'd1,
        CH_RELOAD = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic periodic;
        logic narrow;
    } ch_mode_t;

    typedef struct packed {
        logic  lo;
        logic  hi;
        word_t data;
    } cmp_wr_t;

    // Target reached when the signed distance to it is zero or negative.
    function automatic logic is_reached(cnt_t target, cnt_t now, logic narrow);
        cnt_t  d_full;
        word_t d_half;
        d_full = target - now;
        d_half = target[WORD_W-1:0] - now[WORD_W-1:0];
        if (narrow) begin
            return d_half[WORD_W-1] || (d_half == '0);
        end
        return d_full[CNT_W-1] || (d_full == '0);
    endfunction

    function automatic cnt_t reload_sum(cnt_t target, cnt_t step, logic narrow);
        cnt_t s;
        s = target + step;
        if (narrow) begin
            s[CNT_W-1:WORD_W] = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/evtc_wrap_det.sv
module evtc_wrap_det
    import evtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t cnt_lo,
    output logic  wrapped
);

    word_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= cnt_lo;
        end
    end

    // Low word moved backwards: it rolled over since the previous clock.
    assign wrapped = (cnt_lo < prev_q);

endmodule

// File: rtl/evtc_regs.sv
module evtc_regs
    import evtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ch_mode_t mode,
    input  logic     setval_arm,
    input  cmp_wr_t  wr,
    input  logic     reload_en,
    output cnt_t     cmp_q,
    output cnt_t     reload_nxt,
    output logic     per_zero
);

    cnt_t  per_q;
    logic  setval_q;
    logic  to_cmp;
    word_t lo_per_val;
    word_t hi_per_val;

    assign to_cmp     = !mode.periodic || setval_q;
    assign lo_per_val = mode.narrow ? {1'b0, wr.data[WORD_W-2:0]} : wr.data;
    assign hi_per_val = {1'b0, wr.data[WORD_W-2:0]};
    assign reload_nxt = reload_sum(cmp_q, per_q, mode.narrow);
    assign per_zero   = (per_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= '1;
            per_q    <= '0;
            setval_q <= 1'b0;
        end else begin
            if (setval_arm) begin
                setval_q <= 1'b1;
            end
            if (reload_en) begin
                cmp_q <= reload_nxt;
            end
            if (wr.lo) begin
                if (to_cmp) begin
                    cmp_q[WORD_W-1:0] <= wr.data;
                end
                if (mode.periodic) begin
                    per_q[WORD_W-1:0] <= lo_per_val;
                end
            end
            if (wr.hi) begin
                if (to_cmp) begin
                    cmp_q[CNT_W-1:WORD_W] <= wr.data;
                end
                if (mode.periodic) begin
                    per_q[CNT_W-1:WORD_W] <= hi_per_val;
                end
            end
            if (wr.lo || wr.hi) begin
                setval_q <= 1'b0;
            end
            if (mode.narrow) begin
                cmp_q[CNT_W-1:WORD_W] <= '0;
                per_q[CNT_W-1:WORD_W] <= '0;
            end
        end
    end

    AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr.lo || wr.hi) |=> !setval_q); // R2

    AST_PERIODIC_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode.periodic && !setval_q && wr.lo && !reload_en) |=> $stable(cmp_q[WORD_W-1:0])); // R2

    AST_PERIOD_TOP_NARROW: assert property (@(posedge clk) disable iff (rst)
        (mode.periodic && mode.narrow && wr.lo) |=> !per_q[WORD_W-1]); // R3

    AST_PERIOD_TOP_WIDE: assert property (@(posedge clk) disable iff (rst)
        (mode.periodic && wr.hi) |=> !per_q[CNT_W-1]); // R3

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        mode.narrow |=> (cmp_q[CNT_W-1:WORD_W] == '0) && (per_q[CNT_W-1:WORD_W] == '0)); // R4

endmodule

// File: rtl/evtc_fsm.sv
module evtc_fsm
    import evtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     glb_en,
    input  logic     ch_en,
    input  ch_mode_t mode,
    input  logic     per_zero,
    input  cnt_t     cmp,
    input  cnt_t     sum,
    input  cnt_t     cnt,
    input  logic     wrapped,
    input  logic     wr_any,
    output logic     reload_en,
    output logic     expire
);

    ch_state_e st_q;
    ch_state_e st_d;
    logic      ch_en_q;
    logic      eff_periodic;
    logic      reached;
    logic      sum_ahead;
    logic      live;
    logic      hit;
    logic      wrap_hit;
    logic      en_rise;
    logic      en_fall;

    assign eff_periodic = mode.periodic && !per_zero;
    assign reached      = is_reached(cmp, cnt, mode.narrow);
    assign sum_ahead    = !is_reached(sum, cnt, mode.narrow);
    assign live         = glb_en && ch_en && (st_q == CH_WATCH);
    assign hit          = live && reached;
    assign wrap_hit     = live && mode.narrow && !mode.periodic && wrapped;
    assign en_rise      = ch_en && !ch_en_q;
    assign en_fall      = !ch_en && ch_en_q;
    assign reload_en    = eff_periodic && (hit || (st_q == CH_RELOAD));

    always_comb begin
        st_d = st_q;
        case (st_q)
            CH_IDLE: ;
            CH_WATCH: begin
                if (hit) begin
                    if (!eff_periodic) begin
                        st_d = CH_IDLE;
                    end else if (sum_ahead) begin
                        st_d = CH_WATCH;
                    end else begin
                        st_d = CH_RELOAD;
                    end
                end
            end
            CH_RELOAD: begin
                if (!eff_periodic) begin
                    st_d = CH_IDLE;
                end else if (sum_ahead) begin
                    st_d = CH_WATCH;
                end
            end
            default: st_d = CH_IDLE;
        endcase
        if (wr_any && glb_en && ch_en) begin
            st_d = CH_WATCH;
        end
        if (en_rise) begin
            st_d = CH_WATCH;
        end
        if (en_fall) begin
            st_d = CH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CH_IDLE;
            ch_en_q <= 1'b0;
            expire  <= 1'b0;
        end else begin
            st_q    <= st_d;
            ch_en_q <= ch_en;
            expire  <= hit || wrap_hit;
        end
    end

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !expire); // R7

    AST_DISARM_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> (st_q == CH_IDLE)); // R7

    AST_RELOAD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == CH_RELOAD) |=> !expire); // R1

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == CH_IDLE) |=> !expire); // R9

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  main_cnt,
    input  logic              glb_en,
    input  logic              ch_en,
    input  logic              periodic,
    input  logic              narrow,
    input  logic              setval_arm,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    output logic              expire,
    output logic [CNT_W-1:0]  cmp_val
);

    ch_mode_t mode;
    cmp_wr_t  wr;
    cnt_t     cmp_q;
    cnt_t     reload_nxt;
    logic     per_zero;
    logic     reload_en;
    logic     wrapped;

    assign mode.periodic = periodic;
    assign mode.narrow   = narrow;
    assign wr.lo         = wr_lo;
    assign wr.hi         = wr_hi;
    assign wr.data       = wr_data;
    assign cmp_val       = cmp_q;

    evtc_wrap_det u_wrap (
        .clk     (clk),
        .rst     (rst),
        .cnt_lo  (main_cnt[WORD_W-1:0]),
        .wrapped (wrapped)
    );

    evtc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .setval_arm (setval_arm),
        .wr         (wr),
        .reload_en  (reload_en),
        .cmp_q      (cmp_q),
        .reload_nxt (reload_nxt),
        .per_zero   (per_zero)
    );

    evtc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .glb_en    (glb_en),
        .ch_en     (ch_en),
        .mode      (mode),
        .per_zero  (per_zero),
        .cmp       (cmp_q),
        .sum       (reload_nxt),
        .cnt       (main_cnt),
        .wrapped   (wrapped),
        .wr_any    (wr_lo || wr_hi),
        .reload_en (reload_en),
        .expire    (expire)
    );

endmodule

// File: tb/tb_evt_cmp_channel.sv
module tb_evt_cmp_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] main_cnt = '0;
    logic        glb_en = 1'b0;
    logic        ch_en = 1'b0;
    logic        periodic = 1'b0;
    logic        narrow = 1'b0;
    logic        setval_arm = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        expire;
    logic [63:0] cmp_val;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned pulses = 0;
    int unsigned base = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    evt_cmp_channel dut (
        .clk        (clk),
        .rst        (rst),
        .main_cnt   (main_cnt),
        .glb_en     (glb_en),
        .ch_en      (ch_en),
        .periodic   (periodic),
        .narrow     (narrow),
        .setval_arm (setval_arm),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .expire     (expire),
        .cmp_val    (cmp_val)
    );

    always @(posedge clk) if (expire) pulses <= pulses + 1;

    typedef struct packed {
        logic [63:0] cmpv;
        logic [63:0] cnt;
        logic        nar;
        logic [1:0]  n_exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'd100, 64'd50, 1'b0, 2'd0},                                        // R6 ahead
        '{64'd100, 64'd100, 1'b0, 2'd1},                                       // R6 equality
        '{64'd100, 64'd101, 1'b0, 2'd1},                                       // R6 past
        '{64'd5, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 2'd0},                         // R6 wrap ahead
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'd5, 1'b0, 2'd1},                         // R6 wrap past
        '{64'h10, 64'h7_0000_0008, 1'b1, 2'd0},                                // R4 low word only
        '{64'h10, 64'h7_0000_0008, 1'b0, 2'd1},                                // R6 full width
        '{64'h5, 64'hFFFF_FFF0, 1'b1, 2'd0},                                   // R4 32-bit wrap
        '{64'hDEAD_0000_0030, 64'h40, 1'b1, 2'd1}                              // R4 upper cleared
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(bit hi, logic [31:0] d);
        wr_data = d;
        if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
        step();
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    task automatic arm_setval();
        setval_arm = 1'b1;
        step();
        setval_arm = 1'b0;
    endtask

    task automatic quiet();
        glb_en = 1'b0;
        ch_en  = 1'b0;
        step();
    endtask

    task automatic go(int n);
        ch_en  = 1'b1;
        glb_en = 1'b1;
        base   = pulses;
        repeat (n) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R10: reset state
        check("R10 reset cmp", cmp_val, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 reset expire", {63'd0, expire}, 64'd0);

        // R10: periodic with zero period acts one-shot
        wr_word(1'b0, 32'h40);
        wr_word(1'b1, 32'h0);
        periodic = 1'b1;
        main_cnt = 64'h40;
        step();
        go(8);
        check("R10 zero period pulses", 64'(pulses - base), 64'd1);
        check("R10 zero period cmp", cmp_val, 64'h40);

        // R6 R4: vector table, one-shot
        periodic = 1'b0;
        for (int i = 0; i < NV; i++) begin
            quiet();
            narrow   = VECS[i].nar;
            main_cnt = VECS[i].cnt;
            wr_word(1'b0, VECS[i].cmpv[31:0]);
            wr_word(1'b1, VECS[i].cmpv[63:32]);
            step();
            check(VECS[i].nar ? "R4 cmp readback" : "R6 cmp readback", cmp_val,
                  VECS[i].nar ? {32'd0, VECS[i].cmpv[31:0]} : VECS[i].cmpv);
            go(4);
            check(VECS[i].nar ? "R4 vector pulses" : "R6 vector pulses",
                  64'(pulses - base), 64'(VECS[i].n_exp));
        end
        quiet();
        narrow = 1'b0;

        // R2: write routing with set-value handshake
        periodic = 1'b1;
        arm_setval();
        wr_word(1'b0, 32'd100);
        arm_setval();
        wr_word(1'b1, 32'd0);
        wr_word(1'b0, 32'd30);
        step();
        check("R2 periodic write keeps cmp", cmp_val, 64'd100);

        // R1: periodic reload while counter ramps
        main_cnt = 64'd0;
        step();
        ch_en  = 1'b1;
        glb_en = 1'b1;
        base   = pulses;
        for (int c = 1; c <= 165; c++) begin
            main_cnt = 64'(c);
            step();
        end
        repeat (3) step();
        check("R1 periodic pulses", 64'(pulses - base), 64'd3);
        check("R1 periodic cmp", cmp_val, 64'd190);

        // R1: catch-up after counter jump, single pulse
        glb_en   = 1'b0;
        main_cnt = 64'd300;
        step();
        base   = pulses;
        glb_en = 1'b1;
        repeat (8) step();
        check("R1 catch-up pulses", 64'(pulses - base), 64'd1);
        check("R1 catch-up cmp", cmp_val, 64'd310);

        // R3: period clamp, 32-bit mode
        quiet();
        narrow = 1'b1;
        arm_setval();
        wr_word(1'b0, 32'h50);
        wr_word(1'b0, 32'h8000_0010);
        main_cnt = 64'h50;
        step();
        check("R3 narrow cmp before", cmp_val, 64'h50);
        go(4);
        check("R3 narrow pulses", 64'(pulses - base), 64'd1);
        check("R3 narrow cmp after", cmp_val, 64'h60);

        // R3: period clamp, 64-bit mode
        quiet();
        narrow = 1'b0;
        arm_setval();
        wr_word(1'b0, 32'h0);
        wr_word(1'b1, 32'h8000_0000);
        wr_word(1'b0, 32'h20);
        main_cnt = 64'h0;
        step();
        check("R3 wide cmp before", cmp_val, 64'h0);
        go(6);
        check("R3 wide cmp after", cmp_val, 64'h20);

        // R5: 32-bit one-shot rollover then match
        quiet();
        periodic = 1'b0;
        narrow   = 1'b1;
        wr_word(1'b0, 32'h10);
        main_cnt = 64'hFFFF_FFFD;
        step();
        go(1);
        for (int k = 0; k < 23; k++) begin
            main_cnt = main_cnt + 64'd1;
            step();
        end
        repeat (3) step();
        check("R5 rollover plus match", 64'(pulses - base), 64'd2);

        // R5: rollover and match on the same edge
        quiet();
        wr_word(1'b0, 32'h0);
        main_cnt = 64'hFFFF_FFFE;
        step();
        go(1);
        main_cnt = 64'hFFFF_FFFF;
        step();
        main_cnt = 64'h1_0000_0000;
        step();
        repeat (4) step();
        check("R5 coincident single pulse", 64'(pulses - base), 64'd1);

        // R5: 64-bit mode gives no rollover pulse
        quiet();
        narrow = 1'b0;
        wr_word(1'b0, 32'h5);
        wr_word(1'b1, 32'h1);
        main_cnt = 64'hFFFF_FFFE;
        step();
        go(1);
        for (int k = 0; k < 8; k++) begin
            main_cnt = main_cnt + 64'd1;
            step();
        end
        repeat (3) step();
        check("R5 wide crossing", 64'(pulses - base), 64'd1);

        // R9: pulse timing and width
        quiet();
        wr_word(1'b0, 32'h60);
        wr_word(1'b1, 32'h0);
        main_cnt = 64'h50;
        step();
        go(2);
        check("R9 no early pulse", {63'd0, expire}, 64'd0);
        main_cnt = 64'h60;
        step();
        check("R9 pulse high", {63'd0, expire}, 64'd1);
        step();
        check("R9 pulse one cycle", {63'd0, expire}, 64'd0);

        // R8: write with global enable low does not arm
        quiet();
        wr_word(1'b0, 32'h100);
        main_cnt = 64'h200;
        step();
        go(4);
        glb_en = 1'b0;
        wr_word(1'b0, 32'h1F0);
        base   = pulses;
        glb_en = 1'b1;
        repeat (4) step();
        check("R8 no arm when global off", 64'(pulses - base), 64'd0);
        base = pulses;
        wr_word(1'b0, 32'h1E0);
        repeat (4) step();
        check("R8 write re-arms", 64'(pulses - base), 64'd1);

        // R7: falling edge disarms, rising edge arms
        quiet();
        wr_word(1'b0, 32'h300);
        main_cnt = 64'h100;
        step();
        go(2);
        ch_en = 1'b0;
        step();
        base     = pulses;
        main_cnt = 64'h400;
        repeat (4) step();
        check("R7 disarmed", 64'(pulses - base), 64'd0);
        ch_en = 1'b1;
        repeat (4) step();
        check("R7 rearm on rise", 64'(pulses - base), 64'd1);

        // R7: global enable gates events
        quiet();
        wr_word(1'b0, 32'h380);
        ch_en = 1'b1;
        base  = pulses;
        repeat (4) step();
        check("R7 global gate", 64'(pulses - base), 64'd0);
        glb_en = 1'b1;
        repeat (4) step();
        check("R7 global release", 64'(pulses - base), 64'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule